// File: doc/BRIEF.md
# I2S Philips-Format Master Port with 16-bit Host Words

This block is the master side of a stereo audio port in the Philips I2S format. It generates the serial clock and word select. It shifts transmit samples out on the serial data line and captures receive samples from the serial data input. The host side is 16 bits wide, so every 32-bit channel slot takes two host accesses. The upper halfword always comes first, for both writes and reads.

There are two sample layouts. In full-width mode the whole 32-bit slot carries data. In 24-bit mode the slot carries 24 data bits followed by 8 zero bits. In that mode the host's second halfword carries the low data byte in its upper byte. On transmit the lower byte of that halfword is discarded. On receive it reads back as zero. A polarity input selects whether the serial clock rests low or high, and the frame layout is the same either way. Clock division is outside the block: every `tick` pulse advances the serial clock by one half period.

The control sequence has three states. IDLE is the disabled state: the serial clock rests at its idle level and configuration is captured. LOW is the half period in which the effective clock is low. HIGH is the half period in which it is high. IDLE goes to LOW when `enable` is seen, and the first halfword is loaded at that point. LOW goes to HIGH on a tick; this is the rising effective edge, where receive data is sampled. HIGH goes to LOW on a tick; this is the falling effective edge, where transmit data and word select advance. Any state returns to IDLE when `enable` drops.

Top module: `i2s_hw_port`

## Requirements
- R1: Each channel slot lasts 32 serial clock periods, with the left slot first and then the right. `ws` is 0 for left and 1 for right. It switches one serial clock period before the first bit of the next slot, so the bit with stream index k carries ws = ((k+1) mod 64) >= 32.
- R2: In full-width mode, bits leave MSB first. The first halfword written forms slot bits [31:16] and the second forms bits [15:0].
- R3: In 24-bit mode, the second halfword of a slot puts its bits [15:8] on the line as slot bits [15:8]. Its bits [7:0] are ignored, and 8 zero bits end the slot.
- R4: Received halfwords are presented high then low in line order. In 24-bit mode, the second halfword of each slot reads back with bits [7:0] equal to zero.
- R5: With the port disabled, `sck` rests at the level of `cpol`. The effective clock `sck ^ cpol` rises where input data is sampled and falls where `sd_out` and `ws` change, for both polarity settings.
- R6: `tx_empty` is 1 while the transmit holding word can accept a write and 0 once a write has filled it. `rx_valid` is 1 from the completion of a received halfword until `rx_rd` is pulsed.
- R7: `chan_side` is 0 while a left-slot bit is on the line and 1 during a right-slot bit.
- R8: If no halfword has been written when one is due, 16 zero bits are sent and `underrun` is set. It stays set until the next enable.
- R9: If a received halfword completes while `rx_valid` is still 1, `overrun` is set and the new halfword is dropped. The unread word stays in `rx_rdata`.
- R10: Mode and polarity are captured only while the port is disabled, and changing them during operation has no effect. Enabling starts at the first bit of a left slot.
- R11: After reset, `tx_empty` is 1, `rx_valid`, `underrun` and `overrun` are 0, and `sck` equals `cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the port while 1 |
| mode24 | input | 1 | 1 selects 24-bit samples in 32-bit slots |
| cpol | input | 1 | Idle level of the serial clock |
| tick | input | 1 | Half-period advance strobe for the serial clock |
| tx_wr | input | 1 | Host write strobe |
| tx_wdata | input | 16 | Host write halfword |
| tx_empty | output | 1 | Transmit holding word may be written |
| rx_rd | input | 1 | Host read strobe, consumes `rx_rdata` |
| rx_rdata | output | 16 | Received halfword |
| rx_valid | output | 1 | Received halfword waiting |
| chan_side | output | 1 | Channel of the bit on the line, 1 = right |
| underrun | output | 1 | Transmit data was missing |
| overrun | output | 1 | A received halfword was dropped |
| sck | output | 1 | Serial clock |
| ws | output | 1 | Word select |
| sd_out | output | 1 | Serial transmit data |
| sd_in | input | 1 | Serial receive data |

## Verification
Line outputs move at the clock edge that takes a tick out of HIGH. `sd_out` and `ws` then hold for a full serial period. The bench therefore reads each bit at the falling clock edge right after it sees the effective clock rise, which lands in the middle of a stable bit. `rx_valid` and the received word appear one clock after the rising tick that captures the last bit of a halfword. They are read on that same falling edge, with the data looped back from `sd_out`. `tx_empty` drops one clock after a write and rises one clock after a load. The flag checks are made at falling edges placed after those updates.

// File: rtl/i2s_hw_pkg.sv
package i2s_hw_pkg;

    // Phase of the serial clock sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } clk_phase_e;

endpackage

// File: rtl/i2s_hw_timing.sv
module i2s_hw_timing
    import i2s_hw_pkg::*;
#(
    parameter int HW_W = 16,
    parameter int POS_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       tick,
    input  logic       mode24_in,
    input  logic       cpol_in,
    output clk_phase_e phase,
    output logic       mode_q,
    output logic       pol_q,
    output logic       start_ev,
    output logic       shift_ev,
    output logic       sample_ev,
    output logic       load_ev,
    output logic       load_lo,
    output logic       done_ev,
    output logic       done_lo,
    output logic       side,
    output logic       line_idle,
    output logic       sck,
    output logic       ws
);
    localparam int HW_LOG = $clog2(HW_W);

    clk_phase_e       phase_nx;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] next_pos;
    logic [POS_W-1:0] ahead;

    assign next_pos = pos + POS_W'(1);
    assign ahead    = pos + POS_W'(2);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= ST_IDLE;
        else        phase <= phase_nx;
    end

    // Next state and edge events
    always_comb begin
        phase_nx  = phase;
        start_ev  = 1'b0;
        sample_ev = 1'b0;
        shift_ev  = 1'b0;
        unique case (phase)
            ST_IDLE: begin
                if (enable) begin
                    phase_nx = ST_LOW;
                    start_ev = 1'b1;
                end
            end
            ST_LOW: begin
                if (!enable) begin
                    phase_nx = ST_IDLE;
                end else if (tick) begin
                    phase_nx  = ST_HIGH;
                    sample_ev = 1'b1;
                end
            end
            ST_HIGH: begin
                if (!enable) begin
                    phase_nx = ST_IDLE;
                end else if (tick) begin
                    phase_nx = ST_LOW;
                    shift_ev = 1'b1;
                end
            end
            default: phase_nx = ST_IDLE;
        endcase
    end

    // Bit position, word select and configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos    <= '0;
            ws     <= 1'b0;
            mode_q <= 1'b0;
            pol_q  <= 1'b0;
        end else begin
            if (phase == ST_IDLE) begin
                mode_q <= mode24_in;
                pol_q  <= cpol_in;
                pos    <= '0;
                ws     <= 1'b0;
            end else if (shift_ev) begin
                pos <= next_pos;
                ws  <= ahead[POS_W-1];
            end
        end
    end

    // Outputs
    always_comb begin
        load_ev   = start_ev | (shift_ev & (next_pos[HW_LOG-1:0] == '0));
        load_lo   = shift_ev & next_pos[HW_LOG];
        done_ev   = sample_ev & (pos[HW_LOG-1:0] == '1);
        done_lo   = pos[HW_LOG];
        side      = pos[POS_W-1];
        line_idle = (phase == ST_IDLE);
        sck       = (phase == ST_HIGH) ^ pol_q;
    end

endmodule

// File: rtl/i2s_hw_tx.sv
module i2s_hw_tx #(
    parameter int HW_W = 16,
    parameter int PAD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_ev,
    input  logic            shift_ev,
    input  logic            load_ev,
    input  logic            load_lo,
    input  logic            line_idle,
    input  logic            mode_q,
    input  logic            wr,
    input  logic [HW_W-1:0] wdata,
    output logic            empty,
    output logic            sd,
    output logic            underrun
);
    logic            full;
    logic [HW_W-1:0] hold;
    logic [HW_W-1:0] shreg;
    logic [HW_W-1:0] load_val;

    always_comb begin
        if (mode_q && load_lo) load_val = {hold[HW_W-1:PAD_W], {PAD_W{1'b0}}};
        else                   load_val = hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full     <= 1'b0;
            hold     <= '0;
            shreg    <= '0;
            underrun <= 1'b0;
        end else begin
            if (full) begin
                full <= !load_ev;
            end else if (wr) begin
                full <= 1'b1;
                hold <= wdata;
            end

            if (load_ev) begin
                shreg <= full ? load_val : '0;
            end else if (shift_ev) begin
                shreg <= {shreg[HW_W-2:0], 1'b0};
            end else if (line_idle) begin
                shreg <= '0;
            end

            if (start_ev)                underrun <= !full;
            else if (load_ev && !full)   underrun <= 1'b1;
        end
    end

    assign empty = !full;
    assign sd    = shreg[HW_W-1];

endmodule

// File: rtl/i2s_hw_rx.sv
module i2s_hw_rx #(
    parameter int HW_W = 16,
    parameter int PAD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_ev,
    input  logic            sample_ev,
    input  logic            done_ev,
    input  logic            done_lo,
    input  logic            mode_q,
    input  logic            sd,
    input  logic            rd,
    output logic [HW_W-1:0] rdata,
    output logic            valid,
    output logic            overrun
);
    logic [HW_W-1:0] shreg;
    logic [HW_W-1:0] word;
    logic [HW_W-1:0] word_m;
    logic            still_valid;

    always_comb begin
        word        = {shreg[HW_W-2:0], sd};
        word_m      = (mode_q && done_lo) ? {word[HW_W-1:PAD_W], {PAD_W{1'b0}}} : word;
        still_valid = valid && !rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            rdata   <= '0;
            valid   <= 1'b0;
            overrun <= 1'b0;
        end else if (start_ev) begin
            shreg   <= '0;
            valid   <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (sample_ev) shreg <= word;
            if (done_ev) begin
                valid <= 1'b1;
                if (still_valid) overrun <= 1'b1;
                else             rdata   <= word_m;
            end else begin
                valid <= still_valid;
            end
        end
    end

endmodule

// File: rtl/i2s_hw_port.sv
module i2s_hw_port
    import i2s_hw_pkg::*;
#(
    parameter int HW_W = 16,
    parameter int PAD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            mode24,
    input  logic            cpol,
    input  logic            tick,
    input  logic            tx_wr,
    input  logic [HW_W-1:0] tx_wdata,
    output logic            tx_empty,
    input  logic            rx_rd,
    output logic [HW_W-1:0] rx_rdata,
    output logic            rx_valid,
    output logic            chan_side,
    output logic            underrun,
    output logic            overrun,
    output logic            sck,
    output logic            ws,
    output logic            sd_out,
    input  logic            sd_in
);
    localparam int SLOT_W = 2 * HW_W;
    localparam int POS_W  = $clog2(2 * SLOT_W);

    clk_phase_e phase;
    logic       mode_q;
    logic       pol_q;
    logic       start_ev;
    logic       shift_ev;
    logic       sample_ev;
    logic       load_ev;
    logic       load_lo;
    logic       done_ev;
    logic       done_lo;
    logic       line_idle;

    i2s_hw_timing #(.HW_W(HW_W), .POS_W(POS_W)) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .mode24_in (mode24),
        .cpol_in   (cpol),
        .phase     (phase),
        .mode_q    (mode_q),
        .pol_q     (pol_q),
        .start_ev  (start_ev),
        .shift_ev  (shift_ev),
        .sample_ev (sample_ev),
        .load_ev   (load_ev),
        .load_lo   (load_lo),
        .done_ev   (done_ev),
        .done_lo   (done_lo),
        .side      (chan_side),
        .line_idle (line_idle),
        .sck       (sck),
        .ws        (ws)
    );

    i2s_hw_tx #(.HW_W(HW_W), .PAD_W(PAD_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ev  (start_ev),
        .shift_ev  (shift_ev),
        .load_ev   (load_ev),
        .load_lo   (load_lo),
        .line_idle (line_idle),
        .mode_q    (mode_q),
        .wr        (tx_wr),
        .wdata     (tx_wdata),
        .empty     (tx_empty),
        .sd        (sd_out),
        .underrun  (underrun)
    );

    i2s_hw_rx #(.HW_W(HW_W), .PAD_W(PAD_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ev  (start_ev),
        .sample_ev (sample_ev),
        .done_ev   (done_ev),
        .done_lo   (done_lo),
        .mode_q    (mode_q),
        .sd        (sd_in),
        .rd        (rx_rd),
        .rdata     (rx_rdata),
        .valid     (rx_valid),
        .overrun   (overrun)
    );

endmodule

// File: rtl/i2s_hw_port_chk.sv
module i2s_hw_port_chk
    import i2s_hw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       cpol,
    input logic       sck,
    input logic       ws,
    input logic       sd_out,
    input logic       underrun,
    input logic       overrun,
    input logic       rx_valid,
    input logic       rx_rd,
    input clk_phase_e phase,
    input logic       mode_q,
    input logic       pol_q
);
    logic eff;
    assign eff = sck ^ pol_q;

    assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !$past(enable) && !$past(enable, 2) && $stable(cpol)) |-> (sck == cpol));

    assert_sd_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != ST_IDLE && $past(phase) != ST_IDLE && !$stable(sd_out)) |-> ($past(eff) && !eff));

    assert_ws_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != ST_IDLE && $past(phase) != ST_IDLE && !$stable(ws)) |-> ($past(eff) && !eff));

    assert_underrun_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> !sd_out);

    assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_rd && phase != ST_IDLE) |=> rx_valid);

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && phase != ST_IDLE) |=> overrun);

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != ST_IDLE && $past(phase) != ST_IDLE) |-> ($stable(mode_q) && $stable(pol_q)));

endmodule

bind i2s_hw_port i2s_hw_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .cpol     (cpol),
    .sck      (sck),
    .ws       (ws),
    .sd_out   (sd_out),
    .underrun (underrun),
    .overrun  (overrun),
    .rx_valid (rx_valid),
    .rx_rd    (rx_rd),
    .phase    (phase),
    .mode_q   (mode_q),
    .pol_q    (pol_q)
);

// File: tb/i2s_hw_port_bench.sv
module i2s_hw_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        mode24 = 1'b0;
    logic        cpol = 1'b0;
    logic        tick = 1'b0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        tx_empty;
    logic        rx_rd = 1'b0;
    logic [15:0] rx_rdata;
    logic        rx_valid;
    logic        chan_side;
    logic        underrun;
    logic        overrun;
    logic        sck;
    logic        ws;
    logic        sd_out;
    logic        sd_in;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int wd = 0;

    assign sd_in = sd_out;

    always #5 clk = ~clk;

    i2s_hw_port u_i2s_hw_port (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode24(mode24), .cpol(cpol),
        .tick(tick), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_empty(tx_empty),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_valid(rx_valid),
        .chan_side(chan_side), .underrun(underrun), .overrun(overrun),
        .sck(sck), .ws(ws), .sd_out(sd_out), .sd_in(sd_in)
    );

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", wd);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Halfword as it should appear on the line and in the receive buffer.
    function automatic logic [15:0] line_hw(input logic [15:0] v, input bit m24, input int idx);
        if (m24 && (idx % 2 == 1)) return {v[15:8], 8'h00};
        return v;
    endfunction

    task automatic run_stream(input bit m24, input bit pol, input int nsup,
                              input int nextra, input bit no_read, input bit flip);
        logic [15:0] sent [0:63];
        int ntot = nsup + nextra;
        int k = 0;
        int ri = 0;
        int wi = 0;
        int guard = 0;
        bit prev_ek = 1'b0;
        bit first = 1'b1;
        logic [15:0] hw;
        string dreq;
        for (int i = 0; i < 64; i++) sent[i] = (i < nsup) ? 16'($urandom) : 16'h0000;

        mode24 = m24;
        cpol = pol;
        enable = 1'b0;
        repeat (3) @(negedge clk);
        chk(sck == pol, "R5", "idle sck", int'(sck), int'(pol));

        tx_wr = 1'b1;
        tx_wdata = sent[0];
        wi = 1;
        @(negedge clk);
        tx_wr = 1'b0;
        chk(tx_empty == 1'b0, "R6", "tx_empty after write", int'(tx_empty), 0);
        enable = 1'b1;

        while ((k < ntot * 16 || (!no_read && ri < ntot)) && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (flip) begin
                mode24 = !m24;
                cpol = !pol;
            end
            if (first) begin
                chk(tx_empty == 1'b1, "R6", "tx_empty after load", int'(tx_empty), 1);
                first = 1'b0;
            end
            if (((sck ^ pol) == 1'b1) && !prev_ek && k < ntot * 16) begin
                hw = line_hw(sent[k / 16], m24, k / 16);
                dreq = (k / 16 >= nsup) ? "R8" : (m24 ? "R3" : "R2");
                if (flip) dreq = "R10";
                chk(sd_out == hw[15 - (k % 16)], dreq, $sformatf("sd bit %0d", k),
                    int'(sd_out), int'(hw[15 - (k % 16)]));
                chk(ws == (((k + 1) % 64) >= 32), (k == 0) ? "R10" : "R1",
                    $sformatf("ws bit %0d", k), int'(ws), int'(((k + 1) % 64) >= 32));
                chk(chan_side == ((k % 64) >= 32), "R7", $sformatf("side bit %0d", k),
                    int'(chan_side), int'((k % 64) >= 32));
                k++;
            end
            prev_ek = sck ^ pol;

            rx_rd = 1'b0;
            if (!no_read && rx_valid && ri < ntot) begin
                hw = line_hw(sent[ri], m24, ri);
                chk(rx_rdata == hw, "R4", $sformatf("rx halfword %0d", ri),
                    int'(rx_rdata), int'(hw));
                rx_rd = 1'b1;
                ri++;
            end

            tx_wr = 1'b0;
            if (tx_empty && wi < nsup) begin
                tx_wr = 1'b1;
                tx_wdata = sent[wi];
                wi++;
            end

            tick = (cyc % 3 == 0);
            cyc++;
        end
        tick = 1'b0;
        @(negedge clk);
        rx_rd = 1'b0;
        tx_wr = 1'b0;
        enable = 1'b0;
        @(negedge clk);
        chk(guard < 20000, "R6", "stream completion", guard, 20000);
        chk(underrun == (nextra > 0), "R8", "underrun flag", int'(underrun), int'(nextra > 0));
        if (no_read) begin
            chk(overrun == 1'b1, "R9", "overrun flag", int'(overrun), 1);
            chk(rx_valid == 1'b1, "R9", "rx_valid kept", int'(rx_valid), 1);
            chk(rx_rdata == line_hw(sent[0], m24, 0), "R9", "oldest word kept",
                int'(rx_rdata), int'(line_hw(sent[0], m24, 0)));
        end else begin
            chk(overrun == 1'b0, "R9", "no overrun", int'(overrun), 0);
            chk(rx_valid == 1'b0, "R6", "rx_valid cleared by read", int'(rx_valid), 0);
        end
        repeat (3) @(negedge clk);
        chk(sck == cpol, "R5", "sck idle after disable", int'(sck), int'(cpol));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_empty == 1'b1, "R11", "reset tx_empty", int'(tx_empty), 1);
        chk(rx_valid == 1'b0, "R11", "reset rx_valid", int'(rx_valid), 0);
        chk(underrun == 1'b0, "R11", "reset underrun", int'(underrun), 0);
        chk(overrun == 1'b0, "R11", "reset overrun", int'(overrun), 0);
        chk(sck == cpol, "R11", "reset sck", int'(sck), int'(cpol));

        // Directed: both layouts under both clock polarities
        run_stream(1'b0, 1'b0, 8, 0, 1'b0, 1'b0);
        run_stream(1'b1, 1'b0, 8, 0, 1'b0, 1'b0);
        run_stream(1'b0, 1'b1, 8, 0, 1'b0, 1'b0);
        run_stream(1'b1, 1'b1, 8, 0, 1'b0, 1'b0);

        // Random mixes
        for (int r = 0; r < 6; r++) begin
            run_stream(1'($urandom), 1'($urandom), 4 + int'($urandom % 9), 0, 1'b0, 1'b0);
        end

        // Corner cases: starvation, reads withheld, settings changed while running
        run_stream(1'b0, 1'b0, 4, 4, 1'b0, 1'b0);
        run_stream(1'b1, 1'b1, 3, 2, 1'b0, 1'b0);
        run_stream(1'b1, 1'b0, 6, 0, 1'b1, 1'b0);
        run_stream(1'b0, 1'b0, 8, 0, 1'b0, 1'b1);
        run_stream(1'b1, 1'b1, 8, 0, 1'b0, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule